// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller with Refresh

This block connects a simple processor-side request/ready bus to an asynchronous 64K x 4 DRAM whose row and column addresses share one 8-bit address port. A host access carries a 16-bit address. The controller puts the low byte on the shared pins and drops RAS. It then switches the pin multiplexer to the high byte and drops CAS. Write data and the write strobe are driven before CAS falls. Read data is sampled a fixed number of clocks after CAS falls and is returned to the host together with a one-cycle ready pulse.

A free-running interval timer raises a refresh request at a programmable period. The default of 156 clocks gives about 15.6 µs at 10 MHz, so 256 refreshes fit inside a 4 ms retention window. Each refresh is a RAS-only cycle: CAS stays high, and an 8-bit row counter supplies the row and then advances. When a refresh and a host request are both waiting, the refresh goes first and the host simply sees ready stay low longer. Before every RAS fall, RAS is held high for at least a set number of precharge clocks.

Top module: `mxdram_ctrl`

## Requirements
- R1: While reset is held, RAS, CAS and WE pins are high (inactive), the data-pin drive enable is low and host ready is low.
- R2: At the clock where RAS falls for a host access, the address pins carry request address bits 7..0 (multiplexer select 0 passes the row half).
- R3: At the clock where CAS falls, the address pins carry request address bits 15..8 (multiplexer select 1 passes the column half).
- R4: CAS is low only while RAS is low and only during host accesses, since CAS also acts as the device select.
- R5: For a write, WE is low and the write data is driven at least one clock before CAS falls, and both stay unchanged while CAS is low. For a read, WE stays high.
- R6: A read returns the 4-bit value most recently written to the same 16-bit address, or 0 if that address was never written.
- R7: CAS stays low for exactly T_CAS clocks. Host ready is a single-cycle pulse that rises in the same clock where CAS rises, and at no other time.
- R8: RAS stays high for at least T_RP clocks before each fall.
- R9: A refresh holds RAS low for exactly T_REF clocks with CAS high. Refresh rows run 0, 1, 2, ... and wrap after 255.
- R10: Under continuous host traffic, every one of the 256 rows sees a RAS fall at least once in every span of 257 refresh intervals plus two worst-case access lengths. A host access counts as a refresh of its row.
- R11: A pending refresh beats a pending host request. Consecutive refresh cycles therefore start within one access length, T_RCD+T_CAS+T_RP+T_REF+4 clocks, of the refresh interval, even when host requests never stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Access request, held until ready |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 16 | Word address; bits 7..0 row, 15..8 column |
| host_wdata | input | 4 | Write data |
| host_ready | output | 1 | One-cycle completion pulse |
| host_rdata | output | 4 | Read data, valid with ready |
| dram_addr | output | 8 | Shared row/column address pins |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe and device select, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_dq_oe | output | 1 | Enable for the external data-pin driver |
| dram_dq_out | output | 4 | Data driven toward the DRAM |
| dram_dq_in | input | 4 | Data returned by the DRAM |

## Verification
The bench checks the strobe, address and data pins on every clock. A sequencer that leaves its state a cycle early or late appears at once as a CAS-low length other than T_CAS, or as a ready pulse that does not line up with the CAS rise. A multiplexer select that switches at the wrong time puts the wrong byte on the pins at the first RAS or CAS fall after it, and the returned read data goes wrong on the next read of that address. A refresh row counter or timer fault shows up at the next refresh, as an out-of-order row or a gap between refreshes that is too long. A starved refresh shows up within one refresh interval plus one access.

// File: rtl/mxdram_pkg.sv
package mxdram_pkg;
   typedef enum logic [2:0] {
      ST_PRE  = 3'd0,
      ST_IDLE = 3'd1,
      ST_ACT  = 3'd2,
      ST_COLS = 3'd3,
      ST_CASL = 3'd4,
      ST_REF  = 3'd5
   } seq_state_e;
endpackage

// File: rtl/mxdram_refresh.sv
module mxdram_refresh #(
   parameter int ROW_BITS     = 8,
   parameter int REF_INTERVAL = 156,
   parameter int MAX_WAIT     = 9
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ref_start,
   input  logic                ref_done,
   output logic                ref_pend,
   output logic [ROW_BITS-1:0] ref_row
);
   localparam int TW = (REF_INTERVAL > 2) ? $clog2(REF_INTERVAL) : 1;
   localparam int AGW = $clog2(MAX_WAIT + 2) + 1;
   localparam logic [TW-1:0] T_LAST = TW'(REF_INTERVAL - 1);

   generate
      if (REF_INTERVAL < 2) begin : g_bad_interval
         $error("REF_INTERVAL must be at least 2");
      end
   endgenerate

   logic [TW-1:0] tmr_q;
   logic          tick;

   assign tick = (tmr_q == T_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tmr_q    <= '0;
         ref_pend <= 1'b0;
         ref_row  <= '0;
      end else begin
         tmr_q <= tick ? '0 : tmr_q + 1'b1;
         if (tick)
            ref_pend <= 1'b1;
         else if (ref_start)
            ref_pend <= 1'b0;
         if (ref_done)
            ref_row <= ref_row + 1'b1;
      end
   end

   // waiting-time monitor for the priority property
   logic [AGW-1:0] age_q;
   always_ff @(posedge clk) begin
      if (!rst_n)
         age_q <= '0;
      else if (!ref_pend)
         age_q <= '0;
      else if (age_q <= AGW'(MAX_WAIT))
         age_q <= age_q + 1'b1;
   end

   // R11
   pend_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ref_pend |-> (age_q <= AGW'(MAX_WAIT)));

   // R9
   row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ref_done |=> (ref_row == $past(ref_row) + 1'b1));
endmodule

// File: rtl/mxdram_addr_mux.sv
module mxdram_addr_mux #(
   parameter int ROW_BITS = 8
) (
   input  logic                  sel_col,
   input  logic                  sel_ref,
   input  logic [2*ROW_BITS-1:0] req_addr,
   input  logic [ROW_BITS-1:0]   ref_row,
   output logic [ROW_BITS-1:0]   pin_addr
);
   generate
      for (genvar i = 0; i < ROW_BITS; i++) begin : g_bit
         logic row_bit;
         assign row_bit     = sel_ref ? ref_row[i] : req_addr[i];
         assign pin_addr[i] = sel_col ? req_addr[ROW_BITS+i] : row_bit;
      end
   endgenerate
endmodule

// File: rtl/mxdram_seq.sv
module mxdram_seq
   import mxdram_pkg::*;
#(
   parameter int ROW_BITS  = 8,
   parameter int DATA_BITS = 4,
   parameter int T_RCD     = 2,
   parameter int T_CAS     = 2,
   parameter int T_RP      = 2,
   parameter int T_REF     = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  host_req,
   input  logic                  host_we,
   input  logic [2*ROW_BITS-1:0] host_addr,
   input  logic [DATA_BITS-1:0]  host_wdata,
   output logic                  host_ready,
   output logic [DATA_BITS-1:0]  host_rdata,
   input  logic                  ref_pend,
   output logic                  ref_start,
   output logic                  ref_done,
   output logic [2*ROW_BITS-1:0] addr_lat,
   output logic                  sel_col,
   output logic                  sel_ref,
   output logic                  ras_n,
   output logic                  cas_n,
   output logic                  we_n,
   output logic                  dq_oe,
   output logic [DATA_BITS-1:0]  dq_out,
   input  logic [DATA_BITS-1:0]  dq_in
);
   localparam int CW = $clog2(T_RCD + T_CAS + T_RP + T_REF + 1);
   localparam int HW = $clog2(T_RP + 2) + 1;

   generate
      if (T_RCD < 1 || T_CAS < 1 || T_RP < 1 || T_REF < 1) begin : g_bad_timing
         $error("all strobe timings must be at least one clock");
      end
   endgenerate

   seq_state_e     state_q, state_d;
   logic [CW-1:0]  cnt_q, cnt_d;
   logic           we_q;
   logic           take_host, ready_d, cap_rd;

   always_comb begin
      state_d   = state_q;
      cnt_d     = cnt_q;
      ref_start = 1'b0;
      ref_done  = 1'b0;
      take_host = 1'b0;
      ready_d   = 1'b0;
      cap_rd    = 1'b0;
      unique case (state_q)
         ST_PRE: begin
            if (cnt_q == '0) state_d = ST_IDLE;
            else             cnt_d   = cnt_q - 1'b1;
         end
         ST_IDLE: begin
            if (ref_pend) begin
               state_d   = ST_REF;
               cnt_d     = CW'(T_REF - 1);
               ref_start = 1'b1;
            end else if (host_req) begin
               state_d   = ST_ACT;
               cnt_d     = CW'(T_RCD - 1);
               take_host = 1'b1;
            end
         end
         ST_ACT: begin
            if (cnt_q == '0) state_d = ST_COLS;
            else             cnt_d   = cnt_q - 1'b1;
         end
         ST_COLS: begin
            state_d = ST_CASL;
            cnt_d   = CW'(T_CAS - 1);
         end
         ST_CASL: begin
            if (cnt_q == '0) begin
               state_d = ST_PRE;
               cnt_d   = CW'(T_RP - 1);
               ready_d = 1'b1;
               cap_rd  = !we_q;
            end else begin
               cnt_d = cnt_q - 1'b1;
            end
         end
         ST_REF: begin
            if (cnt_q == '0) begin
               state_d  = ST_PRE;
               cnt_d    = CW'(T_RP - 1);
               ref_done = 1'b1;
            end else begin
               cnt_d = cnt_q - 1'b1;
            end
         end
         default: begin
            state_d = ST_PRE;
            cnt_d   = CW'(T_RP - 1);
         end
      endcase
   end

   logic in_row, in_data;
   assign in_row  = (state_d == ST_ACT) || (state_d == ST_COLS) ||
                    (state_d == ST_CASL) || (state_d == ST_REF);
   assign in_data = (state_d == ST_COLS) || (state_d == ST_CASL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_PRE;
         cnt_q      <= CW'(T_RP - 1);
         we_q       <= 1'b0;
         addr_lat   <= '0;
         dq_out     <= '0;
         host_ready <= 1'b0;
         host_rdata <= '0;
         ras_n      <= 1'b1;
         cas_n      <= 1'b1;
         we_n       <= 1'b1;
         dq_oe      <= 1'b0;
         sel_col    <= 1'b0;
         sel_ref    <= 1'b0;
      end else begin
         state_q    <= state_d;
         cnt_q      <= cnt_d;
         host_ready <= ready_d;
         if (take_host) begin
            we_q     <= host_we;
            addr_lat <= host_addr;
            dq_out   <= host_wdata;
         end
         if (cap_rd)
            host_rdata <= dq_in;
         ras_n   <= !in_row;
         cas_n   <= !(state_d == ST_CASL);
         sel_col <= in_data;
         sel_ref <= (state_d == ST_REF);
         we_n    <= !(in_data && (take_host ? host_we : we_q));
         dq_oe   <= in_data && (take_host ? host_we : we_q);
      end
   end

   // precharge monitor: consecutive clocks with RAS high
   logic [HW-1:0] hi_cnt;
   always_ff @(posedge clk) begin
      if (!rst_n)
         hi_cnt <= '0;
      else if (!ras_n)
         hi_cnt <= '0;
      else if (hi_cnt <= HW'(T_RP))
         hi_cnt <= hi_cnt + 1'b1;
   end

   // R8
   precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n) |-> (hi_cnt >= HW'(T_RP)));

   // R4
   cas_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cas_n |-> !ras_n);

   // R5
   we_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cas_n) |-> ($stable(we_n) && $stable(dq_oe)));

   // R7
   ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_ready |=> !host_ready);
endmodule

// File: rtl/mxdram_ctrl.sv
module mxdram_ctrl #(
   parameter int ROW_BITS     = 8,
   parameter int DATA_BITS    = 4,
   parameter int T_RCD        = 2,
   parameter int T_CAS        = 2,
   parameter int T_RP         = 2,
   parameter int T_REF        = 3,
   parameter int REF_INTERVAL = 156
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  host_req,
   input  logic                  host_we,
   input  logic [2*ROW_BITS-1:0] host_addr,
   input  logic [DATA_BITS-1:0]  host_wdata,
   output logic                  host_ready,
   output logic [DATA_BITS-1:0]  host_rdata,
   output logic [ROW_BITS-1:0]   dram_addr,
   output logic                  dram_ras_n,
   output logic                  dram_cas_n,
   output logic                  dram_we_n,
   output logic                  dram_dq_oe,
   output logic [DATA_BITS-1:0]  dram_dq_out,
   input  logic [DATA_BITS-1:0]  dram_dq_in
);
   localparam int AW       = 2 * ROW_BITS;
   localparam int MAX_WAIT = T_RCD + T_CAS + T_RP + 2;
   localparam int CYCLE    = T_RCD + T_CAS + T_RP + T_REF + 4;

   generate
      if (REF_INTERVAL <= CYCLE) begin : g_bad_period
         $error("REF_INTERVAL too short for one access plus one refresh");
      end
   endgenerate

   logic                ref_pend, ref_start, ref_done;
   logic [ROW_BITS-1:0] ref_row;
   logic [AW-1:0]       addr_lat;
   logic                sel_col, sel_ref;

   mxdram_refresh #(
      .ROW_BITS(ROW_BITS), .REF_INTERVAL(REF_INTERVAL), .MAX_WAIT(MAX_WAIT)
   ) u_refresh (
      .clk(clk), .rst_n(rst_n), .ref_start(ref_start), .ref_done(ref_done),
      .ref_pend(ref_pend), .ref_row(ref_row)
   );

   mxdram_seq #(
      .ROW_BITS(ROW_BITS), .DATA_BITS(DATA_BITS),
      .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .T_REF(T_REF)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_ready(host_ready), .host_rdata(host_rdata),
      .ref_pend(ref_pend), .ref_start(ref_start), .ref_done(ref_done),
      .addr_lat(addr_lat), .sel_col(sel_col), .sel_ref(sel_ref),
      .ras_n(dram_ras_n), .cas_n(dram_cas_n), .we_n(dram_we_n),
      .dq_oe(dram_dq_oe), .dq_out(dram_dq_out), .dq_in(dram_dq_in)
   );

   mxdram_addr_mux #(.ROW_BITS(ROW_BITS)) u_mux (
      .sel_col(sel_col), .sel_ref(sel_ref), .req_addr(addr_lat),
      .ref_row(ref_row), .pin_addr(dram_addr)
   );

   // R2
   row_mux_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(dram_ras_n) && !sel_ref) |-> (dram_addr == addr_lat[ROW_BITS-1:0]));

   // R3
   col_mux_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dram_cas_n) |-> (dram_addr == addr_lat[AW-1:ROW_BITS]));

   // R9
   ref_row_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(dram_ras_n) && sel_ref) |-> (dram_addr == ref_row && dram_cas_n));
endmodule

// File: tb/mxdram_ctrl_test.sv
module mxdram_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int T_RCD = 2, T_CAS = 2, T_RP = 2, T_REF = 3;
   localparam int REF_INT = 40;
   localparam int L_ACC   = T_RCD + T_CAS + T_RP + T_REF + 4;
   localparam int WINDOW  = 257 * REF_INT + 2 * L_ACC;

   logic        clk = 0, rst_n = 0;
   logic        host_req = 0, host_we = 0;
   logic [15:0] host_addr = '0;
   logic [3:0]  host_wdata = '0;
   logic        host_ready;
   logic [3:0]  host_rdata;
   logic [7:0]  dram_addr;
   logic        dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe;
   logic [3:0]  dram_dq_out;
   logic [3:0]  dram_dq_in = '0;

   mxdram_ctrl #(
      .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .T_REF(T_REF),
      .REF_INTERVAL(REF_INT)
   ) uut (
      .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
      .host_rdata(host_rdata), .dram_addr(dram_addr), .dram_ras_n(dram_ras_n),
      .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_dq_oe(dram_dq_oe),
      .dram_dq_out(dram_dq_out), .dram_dq_in(dram_dq_in)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   int  total = 0, fails = 0, cyc = 0;
   bit  mon_en = 0, finished = 0;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(bit ok, string req, string what, int act, int exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // DRAM model and scoreboard
   logic [3:0] dmem [int];
   logic [3:0] smem [int];
   function automatic logic [3:0] dget(int k);
      return dmem.exists(k) ? dmem[k] : 4'h0;
   endfunction
   function automatic logic [3:0] sget(int k);
      return smem.exists(k) ? smem[k] : 4'h0;
   endfunction

   logic [15:0] cur_addr = '0;
   logic        cur_we = 0;
   logic [3:0]  cur_wdata = '0;

   logic       p_ras = 1, p_cas = 1, p_we = 1;
   logic [7:0] ras_row = '0;
   int         ras_t = 0, hi_len = T_RP, cas_len = 0;
   bit         saw_cas = 0, have_ref = 0;
   int         last_ref_t = 0, ref_row_exp = 0;
   int         last_hit [256];

   initial for (int i = 0; i < 256; i++) last_hit[i] = 0;

   always @(negedge clk) begin
      if (!dram_cas_n && dram_we_n)
         dram_dq_in <= dget({dram_addr, ras_row});
      if (mon_en) begin
         // R4: device select only inside an access
         chk(dram_cas_n || !dram_ras_n, "R4", "cas low with ras high", dram_cas_n, 1);
         if (p_ras && !dram_ras_n) begin
            chk(hi_len >= T_RP, "R8", "precharge clocks", hi_len, T_RP);
            ras_row = dram_addr;
            ras_t   = cyc;
            saw_cas = 0;
            chk(cyc - last_hit[dram_addr] <= WINDOW, "R10", "row gap",
                cyc - last_hit[dram_addr], WINDOW);
            last_hit[dram_addr] = cyc;
         end
         if (dram_ras_n) hi_len++;
         if (p_cas && !dram_cas_n) begin
            saw_cas = 1;
            cas_len = 1;
            chk(ras_row == cur_addr[7:0], "R2", "row at ras fall", ras_row, cur_addr[7:0]);
            chk(dram_addr == cur_addr[15:8], "R3", "col at cas fall", dram_addr, cur_addr[15:8]);
            chk(dram_we_n == !cur_we && p_we == dram_we_n, "R5", "we setup", dram_we_n, !cur_we);
            if (cur_we) begin
               chk(dram_dq_oe && dram_dq_out == cur_wdata, "R5", "write data",
                   dram_dq_out, cur_wdata);
               dmem[{dram_addr, ras_row}] = dram_dq_out;
            end
         end else if (!dram_cas_n) begin
            cas_len++;
            chk(dram_we_n == p_we, "R5", "we held", dram_we_n, p_we);
         end
         if (!p_cas && dram_cas_n) begin
            chk(cas_len == T_CAS, "R7", "cas low clocks", cas_len, T_CAS);
            chk(host_ready, "R7", "ready with cas rise", host_ready, 1);
         end else begin
            chk(!host_ready, "R7", "stray ready", host_ready, 0);
         end
         if (!p_ras && dram_ras_n) begin
            hi_len = 1;
            if (!saw_cas) begin
               chk(ras_row == 8'(ref_row_exp), "R9", "refresh row", ras_row, ref_row_exp);
               ref_row_exp = (ref_row_exp + 1) % 256;
               chk(cyc - ras_t == T_REF, "R9", "refresh ras low", cyc - ras_t, T_REF);
               if (have_ref) begin
                  chk(ras_t - last_ref_t <= REF_INT + L_ACC, "R11", "refresh late",
                      ras_t - last_ref_t, REF_INT + L_ACC);
                  chk(ras_t - last_ref_t >= REF_INT - L_ACC, "R11", "refresh early",
                      ras_t - last_ref_t, REF_INT - L_ACC);
               end
               have_ref   = 1;
               last_ref_t = ras_t;
            end
         end
      end
      p_ras = dram_ras_n;
      p_cas = dram_cas_n;
      p_we  = dram_we_n;
   end

   task automatic host_op(bit we, logic [15:0] a, logic [3:0] d);
      cur_we = we; cur_addr = a; cur_wdata = d;
      host_we = we; host_addr = a; host_wdata = d; host_req = 1;
      do @(negedge clk); while (!host_ready);
      if (we) smem[a] = d;
      else chk(host_rdata == sget(a), "R6", "read data", host_rdata, sget(a));
      host_req = 0;
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++; fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      summary();
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1 reset state
      chk(dram_ras_n && dram_cas_n && dram_we_n, "R1", "strobes in reset",
          {dram_ras_n, dram_cas_n, dram_we_n}, 3'b111);
      chk(!host_ready && !dram_dq_oe, "R1", "ready/oe in reset",
          {host_ready, dram_dq_oe}, 0);
      rst_n  = 1;
      mon_en = 1;
      // directed corners
      host_op(1, 16'h0000, 4'h5);
      host_op(1, 16'hFFFF, 4'hA);
      host_op(1, 16'h00FF, 4'h3);
      host_op(1, 16'hFF00, 4'hC);
      host_op(0, 16'h0000, 4'h0);
      host_op(0, 16'hFFFF, 4'h0);
      host_op(0, 16'h00FF, 4'h0);
      host_op(0, 16'hFF00, 4'h0);
      host_op(0, 16'h1234, 4'h0);
      // continuous traffic
      begin
         logic [15:0] last_w = 16'h0;
         for (int i = 0; i < 2800; i++) begin
            logic [15:0] a = 16'($urandom);
            logic [3:0]  d = 4'($urandom);
            if (i % 3 == 2) host_op(0, last_w, 4'h0);
            else if (i % 3 == 1) host_op(0, a, 4'h0);
            else begin host_op(1, a, d); last_w = a; end
         end
      end
      // R10 final sweep over all rows
      for (int r = 0; r < 256; r++)
         chk(cyc - last_hit[r] <= WINDOW, "R10", "row stale at end",
             cyc - last_hit[r], WINDOW);
      summary();
   end
endmodule